// File: doc/BRIEF.md
# Selectable-Rate Countdown Timer with Interrupt

An 8-bit down-counter with its own reload register. One of four tick-enable inputs drives it, chosen by a 2-bit rate field in the control register. The four inputs are nominally 4096 Hz, 64 Hz, 1 Hz and one tick per minute. Those tick enables come from a prescaler outside this block. Each time a countdown ends, the counter reloads on the same tick and keeps running. It also raises a sticky event flag, which only the host can clear.

The interrupt output has two modes. In level mode it follows the flag. In pulse mode it is high for one period of the selected tick after every countdown end. In both modes an interrupt-enable bit gates it. A small register port gives the host access to control, count and flag. The port has a 2-bit address, a write strobe and a combinational read path. Reading the count address returns the live counter value.

Top module: `tick_down_timer`

## Requirements
- R1: After reset the control register reads 0x30. This means run off, interrupt enable off, level mode, and rate field 11 (the slowest rate). Count, reload value and flag read 0, and `irq` is low.
- R2: The control register is at address 0. Bit 0 is run, bit 1 is interrupt enable, bit 2 is pulse mode and bits 5:4 are the rate field. Rate 00 selects `rate_tick[0]` (4096 Hz), 01 selects `rate_tick[1]` (64 Hz), 10 selects `rate_tick[2]` (1 Hz) and 11 selects `rate_tick[3]` (1/60 Hz). Ticks on the bits that are not selected have no effect.
- R3: While run is 1, each selected tick decrements a count above 1 by one. While run is 0, the count holds.
- R4: A write to address 1 loads both the reload value and the live count with the written byte. When the write falls in the same cycle as a selected tick, the write wins and no end event occurs.
- R5: A selected tick while running with a count of 1 or 0 ends the countdown. The count is reloaded from the reload value on that same tick, and the flag is set. A reload value of N ≥ 1 therefore gives one end event every N ticks. A reload value of 0 ends the countdown on every tick.
- R6: The flag reads at address 2, bit 0. Writing 1 to that bit clears it, and nothing else does. If an end event and a clear fall in the same cycle, the set wins.
- R7: In level mode `irq` equals interrupt enable AND flag.
- R8: In pulse mode `irq` is interrupt enable AND a pulse bit. The pulse bit rises in the cycle after an end event. It falls after the next selected tick that does not itself end a countdown, so it lasts one tick period.
- R9: Address 1 reads the live count. Address 3 reads 0, and writes to address 3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_tick | input | 4 | One-cycle tick enables: [0] 4096 Hz, [1] 64 Hz, [2] 1 Hz, [3] 1/60 Hz |
| reg_addr | input | 2 | Register address for read and write |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| irq | output | 1 | Timer interrupt, active high |

## Verification
Two functions can land in the same clock edge. The first is a countdown end, which sets the flag. The second is a host write, which may clear the flag or reload the count. Directed cases park the count at 1 and then drive the selected tick in the same cycle as a flag-clear write. The flag must stay set. Another case drives a count write together with the tick. The written value must appear, and no flag must be raised. Random traffic uses small reload values so that such collisions recur often. A reference model built from the requirements judges every cycle.

// File: rtl/timer_pkg.sv
package timer_pkg;
   typedef enum logic [1:0] {
      ADR_CTRL  = 2'd0,
      ADR_COUNT = 2'd1,
      ADR_EVENT = 2'd2,
      ADR_SPARE = 2'd3
   } tmr_addr_e;

   localparam int CTL_RUN_BIT   = 0;
   localparam int CTL_IEN_BIT   = 1;
   localparam int CTL_PULSE_BIT = 2;
   localparam int CTL_RATE_LSB  = 4;
endpackage

// File: rtl/cdt_rate_pick.sv
module cdt_rate_pick #(
   parameter int N_RATES = 4,
   parameter int SEL_W   = $clog2(N_RATES)
) (
   input  logic [N_RATES-1:0] rate_tick,
   input  logic [SEL_W-1:0]   sel,
   output logic               sel_tick
);
   logic [N_RATES-1:0] hit;

   generate
      if (N_RATES < 2) begin : g_bad
         $error("cdt_rate_pick: need at least two rates");
      end
      for (genvar i = 0; i < N_RATES; i++) begin : g_match
         localparam logic [SEL_W-1:0] IDX = SEL_W'(i);
         assign hit[i] = rate_tick[i] && (sel == IDX);
      end
   endgenerate

   assign sel_tick = |hit;
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             step,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] reload,
   output logic             wrap
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   generate
      if (CNT_W < 2) begin : g_bad
         $error("cdt_counter: CNT_W must be at least 2");
      end
   endgenerate

   assign wrap = step && !load && (cnt <= ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         reload <= '0;
      end else if (load) begin
         cnt    <= load_val;
         reload <= load_val;
      end else if (step) begin
         if (cnt <= ONE) cnt <= reload;
         else            cnt <= cnt - ONE;
      end
   end

   AST_LOAD_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt == $past(load_val)) && (reload == $past(load_val))); // R4
   AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && cnt > ONE) |=> cnt == $past(cnt) - ONE); // R3
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !load) |=> $stable(cnt) && $stable(reload)); // R3
   AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> cnt == reload); // R5
endmodule

// File: rtl/cdt_irq_gen.sv
module cdt_irq_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic wrap,
   input  logic sel_tick,
   input  logic clr_req,
   input  logic irq_en,
   input  logic pulse_mode,
   output logic flag,
   output logic irq
);
   logic pulse_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag <= 1'b0;
      else if (wrap)    flag <= 1'b1;
      else if (clr_req) flag <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pulse_q <= 1'b0;
      else if (wrap)     pulse_q <= 1'b1;
      else if (sel_tick) pulse_q <= 1'b0;
   end

   assign irq = irq_en && (pulse_mode ? pulse_q : flag);

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr_req) |=> flag); // R6
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> flag); // R6
   AST_PULSE_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_q && sel_tick && !wrap) |=> !pulse_q); // R8
   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq); // R7
endmodule

// File: rtl/tick_down_timer.sv
module tick_down_timer #(
   parameter int N_RATES = 4,
   parameter int CNT_W   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_RATES-1:0] rate_tick,
   input  logic [1:0]         reg_addr,
   input  logic               reg_we,
   input  logic [CNT_W-1:0]   reg_wdata,
   output logic [CNT_W-1:0]   reg_rdata,
   output logic               irq
);
   import timer_pkg::*;

   localparam int SEL_W = $clog2(N_RATES);

   generate
      if (CNT_W < CTL_RATE_LSB + SEL_W) begin : g_bad
         $error("tick_down_timer: control field does not fit the data width");
      end
   endgenerate

   logic             run_q, ien_q, pmode_q;
   logic [SEL_W-1:0] rate_q;
   logic             sel_tick, wrap, flag;
   logic [CNT_W-1:0] cnt, reload;
   logic             wr_ctrl, wr_count, clr_req;

   assign wr_ctrl  = reg_we && (reg_addr == ADR_CTRL);
   assign wr_count = reg_we && (reg_addr == ADR_COUNT);
   assign clr_req  = reg_we && (reg_addr == ADR_EVENT) && reg_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         ien_q   <= 1'b0;
         pmode_q <= 1'b0;
         rate_q  <= '1;
      end else if (wr_ctrl) begin
         run_q   <= reg_wdata[CTL_RUN_BIT];
         ien_q   <= reg_wdata[CTL_IEN_BIT];
         pmode_q <= reg_wdata[CTL_PULSE_BIT];
         rate_q  <= reg_wdata[CTL_RATE_LSB +: SEL_W];
      end
   end

   cdt_rate_pick #(.N_RATES(N_RATES), .SEL_W(SEL_W)) i_pick (
      .rate_tick (rate_tick),
      .sel       (rate_q),
      .sel_tick  (sel_tick)
   );

   cdt_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_count),
      .load_val (reg_wdata),
      .step     (run_q && sel_tick),
      .cnt      (cnt),
      .reload   (reload),
      .wrap     (wrap)
   );

   cdt_irq_gen i_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .wrap       (wrap),
      .sel_tick   (sel_tick),
      .clr_req    (clr_req),
      .irq_en     (ien_q),
      .pulse_mode (pmode_q),
      .flag       (flag),
      .irq        (irq)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADR_CTRL: begin
            reg_rdata[CTL_RUN_BIT]             = run_q;
            reg_rdata[CTL_IEN_BIT]             = ien_q;
            reg_rdata[CTL_PULSE_BIT]           = pmode_q;
            reg_rdata[CTL_RATE_LSB +: SEL_W]   = rate_q;
         end
         ADR_COUNT: reg_rdata = cnt;
         ADR_EVENT: reg_rdata[0] = flag;
         default:   reg_rdata = '0;
      endcase
   end

   AST_NO_STEP_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !wr_count) |=> $stable(cnt)); // R3
   AST_NO_WRAP_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_count |-> !wrap); // R4
   AST_SPARE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == ADR_SPARE) |=>
         $stable(run_q) && $stable(ien_q) && $stable(pmode_q) && $stable(rate_q)); // R9
endmodule

// File: tb/test_tick_down_timer.sv
module test_tick_down_timer;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] rate_tick = '0;
   logic [1:0] reg_addr = '0;
   logic       reg_we = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       irq;

   int checks = 0;
   int errors = 0;

   // reference state
   logic       m_run, m_ien, m_pm, m_flag, m_pulse;
   logic [1:0] m_sel;
   logic [7:0] m_cnt, m_rel;

   always #(CLK_PERIOD/2) clk = ~clk;

   tick_down_timer i_tick_down_timer (
      .clk(clk), .rst_n(rst_n), .rate_tick(rate_tick), .reg_addr(reg_addr),
      .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   function automatic logic [7:0] exp_ctrl();
      return {2'b00, m_sel, 1'b0, m_pm, m_ien, m_run};
   endfunction

   function automatic logic exp_irq();
      return m_ien && (m_pm ? m_pulse : m_flag);
   endfunction

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic read_at(input logic [1:0] a, output logic [7:0] v);
      reg_addr = a;
      #1;
      v = reg_rdata;
   endtask

   task automatic check_all(input string req);
      logic [7:0] v;
      chk({7'd0, irq}, {7'd0, exp_irq()}, m_pm ? "R8 irq pulse" : "R7 irq level");
      read_at(2'd0, v); chk(v, exp_ctrl(), "R2 ctrl");
      read_at(2'd1, v); chk(v, m_cnt, req);
      read_at(2'd2, v); chk(v, {7'd0, m_flag}, "R6 flag");
      read_at(2'd3, v); chk(v, 8'h00, "R9 spare");
   endtask

   task automatic step(input logic [3:0] tk, input logic we, input logic [1:0] a,
                       input logic [7:0] d);
      logic st, ld, wr;
      @(negedge clk);
      rate_tick = tk; reg_we = we; reg_addr = a; reg_wdata = d;
      st = tk[m_sel];
      ld = we && a == 2'd1;
      wr = !ld && m_run && st && (m_cnt <= 8'd1);
      if (ld) begin
         m_cnt = d; m_rel = d;
      end else if (m_run && st) begin
         m_cnt = (m_cnt <= 8'd1) ? m_rel : m_cnt - 8'd1;
      end
      if (wr) m_flag = 1'b1;
      else if (we && a == 2'd2 && d[0]) m_flag = 1'b0;
      if (wr) m_pulse = 1'b1;
      else if (st) m_pulse = 1'b0;
      if (we && a == 2'd0) begin
         m_run = d[0]; m_ien = d[1]; m_pm = d[2]; m_sel = d[5:4];
      end
      @(posedge clk);
      #1;
      rate_tick = '0; reg_we = 1'b0;
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
      step(4'h0, 1'b1, a, d);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] v;
      void'($urandom(32'h5EED_1234));
      m_run = 0; m_ien = 0; m_pm = 0; m_flag = 0; m_pulse = 0;
      m_sel = 2'b11; m_cnt = 0; m_rel = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      read_at(2'd0, v); chk(v, 8'h30, "R1 ctrl reset");
      read_at(2'd1, v); chk(v, 8'h00, "R1 count reset");
      read_at(2'd2, v); chk(v, 8'h00, "R1 flag reset");
      chk({7'd0, irq}, 8'h00, "R1 irq reset");

      // R3 stopped: ticks ignored
      wr_reg(2'd1, 8'd5);
      step(4'hF, 0, 0, 0); check_all("R3 hold when stopped");

      // R2 each rate: only the chosen bit advances
      for (int k = 0; k < 4; k++) begin
         wr_reg(2'd0, {2'b00, 2'(k), 4'b0001});
         wr_reg(2'd1, 8'd5);
         step(~(4'b0001 << k), 0, 0, 0); check_all("R2 other rate ignored");
         step(4'b0001 << k, 0, 0, 0);    check_all("R2 R3 selected rate decrements");
      end

      // R5 reload 3 at 1 Hz, level irq enabled
      wr_reg(2'd0, 8'b0010_0011);
      wr_reg(2'd1, 8'd3);
      for (int i = 0; i < 3; i++) begin
         step(4'b0100, 0, 0, 0); check_all("R5 countdown end and reload");
      end
      read_at(2'd2, v); chk(v, 8'h01, "R5 flag set at end");
      chk({7'd0, irq}, 8'h01, "R7 level irq high");

      // R6 flag survives a write of 0, cleared by write of 1
      wr_reg(2'd2, 8'h00); check_all("R6 write 0 keeps flag");
      wr_reg(2'd2, 8'h01); check_all("R6 write 1 clears flag");
      chk({7'd0, irq}, 8'h00, "R7 irq follows cleared flag");

      // R6 collision: end event and clear in one cycle
      wr_reg(2'd1, 8'd1);
      step(4'b0100, 1, 2'd2, 8'h01); check_all("R6 set wins over clear");
      read_at(2'd2, v); chk(v, 8'h01, "R6 set wins over clear");

      // R4 collision: count write with selected tick at count 1
      wr_reg(2'd2, 8'h01);
      wr_reg(2'd1, 8'd1);
      step(4'b0100, 1, 2'd1, 8'd9); check_all("R4 write wins over tick");
      read_at(2'd2, v); chk(v, 8'h00, "R4 no end event on write");

      // R8 pulse mode at 64 Hz, reload 2
      wr_reg(2'd0, 8'b0001_0111);
      wr_reg(2'd1, 8'd2);
      step(4'b0010, 0, 0, 0); check_all("R8 pulse before end");
      step(4'b0010, 0, 0, 0); check_all("R8 pulse rises");
      chk({7'd0, irq}, 8'h01, "R8 pulse high after end");
      step(4'b0000, 0, 0, 0); check_all("R8 pulse held between ticks");
      step(4'b0010, 0, 0, 0); check_all("R8 pulse falls after one tick");
      chk({7'd0, irq}, 8'h00, "R8 pulse low after tick");

      // R9 writes to spare address
      wr_reg(2'd3, 8'hFF); check_all("R9 spare write ignored");

      // R5 reload zero ends every tick
      wr_reg(2'd0, 8'b0000_0011);
      wr_reg(2'd1, 8'd0);
      step(4'b0001, 0, 0, 0); check_all("R5 reload zero");
      step(4'b0001, 0, 0, 0); check_all("R5 reload zero");

      // random traffic
      for (int n = 0; n < 3000; n++) begin
         logic [3:0] tk;
         logic       we;
         logic [1:0] a;
         logic [7:0] d;
         tk = 4'($urandom) & 4'($urandom);
         we = ($urandom % 6) == 0;
         a  = 2'($urandom);
         d  = 8'($urandom);
         if (a == 2'd1) d = 8'($urandom % 5);
         if (a == 2'd0) d[0] = ($urandom % 4) != 0;
         step(tk, we, a, d);
         check_all("R3 R5 random count");
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule